// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block gathers event pulses from a CAN controller into a sixteen-bit status word. Each status bit latches when its event pulse arrives. It stays latched until software writes a one to that bit position. A second sixteen-bit word holds the enables. The enables share bit positions with the status bits, and bit 0 of the enable word acts as a master switch. The block drives one active-low interrupt request, `int_n`.

Two sources do not take part in the interrupt as sticky bits. These are the receive-message source and the transmit-message source. Each one is built as a level from the mailbox vectors: the OR, over all mailboxes, of a per-mailbox interrupt enable ANDed with that mailbox's available or done flag. Software reaches both words through a simple write port and a combinational read port. The events themselves are detected elsewhere.

Top module: `can_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_i[k]` for k in 2..15 sets status bit k at the next rising clock edge. The bit reads as 1 from then on.
- R2: A set status bit stays set while events are absent and writes carry 0 in its position. A status write (`wr_sel_i`=0) with a 1 at position k clears bit k at the next edge.
- R3: When an event pulse and a status write with a 1 hit the same bit in the same cycle, the bit stays set.
- R4: Status bits are captured whatever the enable word holds, including all enables at 0.
- R5: Status bit positions: 15 single-shot failure, 14 stuck-dominant, 13 remote reply sent, 10 receive loss, 9 bus-off, 8 CRC, 7 form, 6 ack, 5 stuff, 4 bit error, 3 overload, 2 arbitration loss. `int_n` is 0 when enable bit 0 is 1 and, for at least one of these positions, both the status bit and the enable bit are 1.
- R6: While enable bit 0 is 0, `int_n` is 1, whatever the status, enables and mailbox inputs.
- R7: Receive term: enable bit 12 AND the OR over mailboxes of (`rx_ie_i[i]` AND `rx_av_i[i]`). This term pulls `int_n` low under the master enable, in the same cycle as the mailbox inputs. Status bit 12 is sticky and readable, but it does not drive `int_n` by itself.
- R8: Transmit term: enable bit 11 AND the OR over mailboxes of (`tx_ie_i[i]` AND `tx_done_i[i]`). It follows the same rules as R7, with status bit 11 read only.
- R9: Status bits 1:0 and enable bit 1 always read 0. Events on `evt_i[1:0]` have no effect. The read port returns the enable word when `rd_sel_i`=1 and the status word otherwise.
- R10: During reset and straight after it, both words read 0 and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | One-cycle event pulses, one per status bit |
| rx_ie_i | input | N_RX | Per-mailbox receive interrupt enables |
| rx_av_i | input | N_RX | Per-mailbox message-available flags |
| tx_ie_i | input | N_TX | Per-mailbox transmit interrupt enables |
| tx_done_i | input | N_TX | Per-mailbox request-done flags |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (write-1-to-clear), 1 enable |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 1 | Read source: 0 status, 1 enable |
| rd_data_o | output | 16 | Read data (combinational) |
| int_n | output | 1 | Interrupt request, active low |

## Verification
Writes, status clears and event captures take effect at the rising edge that samples them. The bench drives each of these on a falling edge and reads the result at the next falling edge, one cycle later. The mailbox terms and the read port have no register in their path. For those, the bench changes the input and samples `int_n` or `rd_data_o` one nanosecond later, inside the same cycle. Reset values are sampled while reset is still held, after the first clock edge.

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl #(
  parameter int N_RX = 16,
  parameter int N_TX = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     evt_i,
  input  logic [N_RX-1:0] rx_ie_i,
  input  logic [N_RX-1:0] rx_av_i,
  input  logic [N_TX-1:0] tx_ie_i,
  input  logic [N_TX-1:0] tx_done_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [15:0]     wr_data_i,
  input  logic            rd_sel_i,
  output logic [15:0]     rd_data_o,
  output logic            int_n
);

  localparam logic [15:0] ST_MASK  = 16'hFFFC;
  localparam logic [15:0] EN_MASK  = 16'hFFFD;
  localparam logic [15:0] LVL_MASK = 16'h1800;
  localparam logic [15:0] DIR_MASK = ST_MASK & ~LVL_MASK;
  localparam int          RX_BIT   = 12;
  localparam int          TX_BIT   = 11;

  logic [15:0] st_q, en_q;
  logic [15:0] clr, set, src;
  logic        rx_any, tx_any;

  assign clr = (wr_en_i && !wr_sel_i) ? (wr_data_i & ST_MASK) : 16'h0;
  assign set = evt_i & ST_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 16'h0;
      en_q <= 16'h0;
    end else begin
      st_q <= (st_q & ~clr) | set;
      if (wr_en_i && wr_sel_i) en_q <= wr_data_i & EN_MASK;
    end
  end

  assign rx_any = |(rx_ie_i & rx_av_i);
  assign tx_any = |(tx_ie_i & tx_done_i);

  always_comb begin
    src = st_q & en_q & DIR_MASK;
    src[RX_BIT] = en_q[RX_BIT] & rx_any;
    src[TX_BIT] = en_q[TX_BIT] & tx_any;
  end

  assign int_n     = ~(en_q[0] & (|src));
  assign rd_data_o = rd_sel_i ? en_q : st_q;

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_i & ST_MASK) |=> ((st_q & $past(evt_i & ST_MASK)) == $past(evt_i & ST_MASK)));

  p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i && |(wr_data_i & ST_MASK & ~evt_i))
    |=> ((st_q & $past(wr_data_i & ST_MASK & ~evt_i)) == 16'h0));

  p_race_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i && |(wr_data_i & evt_i & ST_MASK))
    |=> ((st_q & $past(wr_data_i & evt_i & ST_MASK)) == $past(wr_data_i & evt_i & ST_MASK)));

  p_glb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data_o[0] && rd_sel_i |-> int_n);

  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~(rd_sel_i ? EN_MASK : ST_MASK)) == 16'h0);

  p_rst_r10: assert property (@(posedge clk)
    !rst_n |=> (rst_n || int_n));

endmodule

// File: tb/can_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_irq_ctrl_tb_top;
  localparam int N_RX = 16;
  localparam int N_TX = 8;
  localparam int NV   = 8;

  // entry: {event[15:0], enable[15:0], expected int_n}
  localparam logic [32:0] VEC [NV] = '{
    {16'h0004, 16'h0005, 1'b0},
    {16'h0004, 16'h0004, 1'b1},
    {16'h8000, 16'h0001, 1'b1},
    {16'h8000, 16'h8001, 1'b0},
    {16'h0003, 16'hFFFF, 1'b1},
    {16'h1800, 16'h1801, 1'b1},
    {16'h0600, 16'h0201, 1'b0},
    {16'h0100, 16'h0001, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] evt = 0;
  logic [N_RX-1:0] rx_ie = 0, rx_av = 0;
  logic [N_TX-1:0] tx_ie = 0, tx_done = 0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic int_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  can_irq_ctrl #(.N_RX(N_RX), .N_TX(N_TX)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .rx_ie_i(rx_ie), .rx_av_i(rx_av), .tx_ie_i(tx_ie), .tx_done_i(tx_done),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .int_n(int_n));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    @(negedge clk); @(negedge clk);
    // R10 reset state
    check("R10 int_n", {15'h0, int_n}, 16'h1);
    rd(0, v); check("R10 status", v, 16'h0);
    rd(1, v); check("R10 enable", v, 16'h0);
    rst_n = 1;
    @(negedge clk);
    check("R10 int_n after", {15'h0, int_n}, 16'h1);

    for (int i = 0; i < NV; i++) begin
      wr(0, 16'hFFFF);
      wr(1, VEC[i][16:1]);
      pulse(VEC[i][32:17]);
      rd(0, v); check($sformatf("R1/R9 vec%0d status", i), v, VEC[i][32:17] & 16'hFFFC);
      rd(1, v); check($sformatf("R9 vec%0d enable", i), v, VEC[i][16:1] & 16'hFFFD);
      check($sformatf("R5/R6 vec%0d int_n", i), {15'h0, int_n}, {15'h0, VEC[i][0]});
    end

    // R4 capture with all enables off
    wr(0, 16'hFFFF); wr(1, 16'h0000);
    pulse(16'h4000);
    rd(0, v); check("R4 capture", v, 16'h4000);
    check("R6 int_n", {15'h0, int_n}, 16'h1);

    // R2 sticky under zero write, then clear
    repeat (3) @(negedge clk);
    wr(0, 16'h0000);
    rd(0, v); check("R2 hold", v, 16'h4000);
    wr(0, 16'h4000);
    rd(0, v); check("R2 clear", v, 16'h0000);

    // R3 event and clear together
    @(negedge clk); evt = 16'h0100; wr_en = 1; wr_sel = 0; wr_data = 16'h0120;
    @(negedge clk); evt = 0; wr_en = 0;
    rd(0, v); check("R3 race", v, 16'h0100);

    // R7 receive mailbox term
    wr(0, 16'hFFFF); wr(1, 16'h1001);
    rx_ie = 16'h0008; rx_av = 16'h0020; #1;
    check("R7 no match", {15'h0, int_n}, 16'h1);
    rx_av = 16'h0028; #1;
    check("R7 match", {15'h0, int_n}, 16'h0);
    wr(1, 16'h1000);
    check("R6 rx gated", {15'h0, int_n}, 16'h1);
    rx_ie = 0; rx_av = 0;

    // R8 transmit mailbox term
    wr(1, 16'h0801);
    tx_ie = 8'h80; tx_done = 8'h01; #1;
    check("R8 no match", {15'h0, int_n}, 16'h1);
    tx_done = 8'h81; #1;
    check("R8 match", {15'h0, int_n}, 16'h0);
    wr(1, 16'h1001);
    check("R8 wrong enable", {15'h0, int_n}, 16'h1);
    tx_ie = 0; tx_done = 0;

    // R5 sticky sourced interrupt then cleared
    wr(1, 16'h0009); pulse(16'h0008);
    check("R5 overload", {15'h0, int_n}, 16'h0);
    wr(0, 16'h0008);
    check("R5 cleared", {15'h0, int_n}, 16'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule